// File: doc/BRIEF.md
# External Data Space Router with Strobe Stretch

This block sits between a processor's external-data access port and two targets: a small on-chip data SRAM and a slow external memory bus. For each access it decides, from the address and a software-controlled enable, which target serves the request.

Internal accesses complete in a fixed short time. External accesses run a timed address, strobe and hold sequence. The strobe width and the setup and hold padding of that sequence depend on a 3-bit stretch code, so slow RAM and peripherals can be reached without slowing the rest of the system.

The requester raises `req_valid` for one clock while the router is idle. It then waits for the one-clock `done` pulse, which also qualifies `rd_data` for reads. The internal SRAM is a separate macro with one cycle of read latency. The external bus is modelled as plain nets: a full address, separate data out and data in, an output enable, an address latch strobe and active-low read and write strobes. A machine cycle is four clocks.

Top module: `xdata_router`

## Requirements
- R1: With `int_en` = 1 and an address below 0400h, the access goes to the SRAM. `sram_en` is high for exactly one clock, with `sram_addr` = address bits 9..0, `sram_we` equal to the request's write flag and `sram_wdata` equal to its data. No external strobe and no ALE pulse occur.
- R2: With `int_en` = 1 and an address of 0400h or above, the access goes to the external bus and `sram_en` stays low.
- R3: With `int_en` = 0, every address from 0000h to FFFFh, including 0000h to 03FFh, goes to the external bus.
- R4: An internal access raises `done` two clocks after the accepting edge, whatever the stretch code. For a read, `rd_data` then holds the SRAM word at that address.
- R5: The external read or write strobe is low for 2 clocks (half a machine cycle) when the stretch code is 0. For a code n from 1 to 7 it is low for 4·n clocks.
- R6: `ext_ale` is high for the first 2 clocks after acceptance. The strobe starts 4 clocks after acceptance for stretch 0, or 5 clocks after for stretch 1 to 7 (one extra setup clock).
- R7: The hold time after the strobe is 2 clocks for stretch 0 and 3 clocks otherwise. `done` therefore rises 8 clocks after acceptance for stretch 0 and 4·(n+2) clocks after for stretch n > 0, which is 2 to 9 machine cycles.
- R8: An external read returns the `ext_din` value present during the strobe. A write drives only `ext_wr_n` low, never `ext_rd_n`. During a write strobe, `ext_oe` is high and `ext_dout` equals the write data.
- R9: `done` is a one-clock pulse. `ext_addr` holds the accepted address for the whole external access, even if `req_addr` changes.
- R10: The stretch code and `int_en` are sampled at acceptance. Changing either of them during an access does not change that access's route or timing.
- R11: After reset, `done`, `ext_ale`, `ext_oe` and `sram_en` are low, and `ext_rd_n` and `ext_wr_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-clock access request, honoured when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write data |
| int_en | input | 1 | Maps the internal SRAM into 0000h-03FFh |
| stretch | input | 3 | External strobe stretch code |
| rd_data | output | 8 | Read result, valid with `done` |
| done | output | 1 | Access complete pulse |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 10 | SRAM word address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one clock after `sram_en` |
| ext_addr | output | 16 | External address |
| ext_dout | output | 8 | External write data |
| ext_oe | output | 1 | External data output enable |
| ext_din | input | 8 | External read data |
| ext_ale | output | 1 | Address latch strobe |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
Accesses are issued at both edges of the internal window (0000h, 03FFh) and just past it (0400h), with the enable set and cleared. This separates a decode that compares against the wrong limit from one that ignores the enable. Reads and writes to external addresses are swept through all eight stretch codes, so the strobe width, setup position, hold and total latency each show the code-0 special case apart from the linear n > 0 rule. Internal accesses with large stretch codes show that stretch does not leak into the SRAM path. Finally, the stretch code and the enable are changed in the middle of an access, and the request address is scrambled after acceptance, to show that all three are captured at the accepting edge.

// File: rtl/xdata_pkg.sv
// Shared types for the external data space router.
// Assumes nothing beyond the IEEE 1800-2017 language.
package xdata_pkg;
    // Phases of an external bus access
    typedef enum logic [1:0] {
        XS_IDLE,
        XS_ADDR,
        XS_STRB,
        XS_HOLD
    } xphase_t;
endpackage

// File: rtl/xdata_decode.sv
// Address decoder: flags an access for the internal SRAM window.
// Assumes the window starts at address zero and spans INT_BYTES bytes.
module xdata_decode #(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              int_en,
    output logic              to_int
);
    localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(INT_BYTES);

    // Window hit only when the window is mapped in
    always_comb begin
        to_int = int_en && (addr < WIN_LIMIT);
    end
endmodule

// File: rtl/xdata_ext_seq.sv
// External bus sequencer: runs address, strobe and hold phases whose
// lengths follow a stretch code captured at start.
// Assumes start is only raised while idle and MC_CLKS is even.
module xdata_ext_seq
    import xdata_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int ST_W    = 3,
    parameter int MC_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ST_W-1:0]   stretch,
    input  logic [DATA_W-1:0] ext_din,
    output logic              idle,
    output logic              fin,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_oe,
    output logic              ext_ale,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    localparam int HALF     = MC_CLKS / 2;
    localparam int MAX_STRB = ((1 << ST_W) - 1) * MC_CLKS;
    localparam int CNT_W    = $clog2(MAX_STRB + 1);

    xphase_t            phase;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   ph_len;
    logic [ST_W-1:0]    st_q;
    logic               wr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               fin_q;
    logic               stretched;
    logic               ph_last;

    // Length of the current phase from the captured stretch code
    always_comb begin
        stretched = |st_q;
        unique case (phase)
            XS_ADDR: ph_len = CNT_W'(MC_CLKS) + CNT_W'(stretched);
            XS_STRB: ph_len = stretched ? CNT_W'(st_q) * CNT_W'(MC_CLKS)
                                        : CNT_W'(HALF);
            XS_HOLD: ph_len = CNT_W'(HALF) + CNT_W'(stretched);
            default: ph_len = CNT_W'(1);
        endcase
        ph_last = (cnt == ph_len - CNT_W'(1));
    end

    // Phase sequencing, request capture and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= XS_IDLE;
            cnt     <= '0;
            st_q    <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            unique case (phase)
                XS_IDLE: begin
                    if (start) begin
                        phase   <= XS_ADDR;
                        cnt     <= '0;
                        st_q    <= stretch;
                        wr_q    <= write;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                    end
                end
                XS_ADDR: begin
                    if (ph_last) begin
                        phase <= XS_STRB;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                XS_STRB: begin
                    if (ph_last) begin
                        phase <= XS_HOLD;
                        cnt   <= '0;
                        if (!wr_q) begin
                            rdata_q <= ext_din;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                XS_HOLD: begin
                    if (ph_last) begin
                        phase <= XS_IDLE;
                        cnt   <= '0;
                        fin_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= XS_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the registered phase
    always_comb begin
        idle     = (phase == XS_IDLE);
        fin      = fin_q;
        rdata    = rdata_q;
        ext_addr = addr_q;
        ext_dout = wdata_q;
        ext_ale  = (phase == XS_ADDR) && (cnt < CNT_W'(HALF));
        ext_rd_n = !((phase == XS_STRB) && !wr_q);
        ext_wr_n = !((phase == XS_STRB) && wr_q);
        ext_oe   = wr_q && ((phase == XS_STRB) || (phase == XS_HOLD));
    end

    // Run length of the current strobe, kept for the bound check
    logic [CNT_W:0] strb_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_run <= '0;
        end else if (!ext_rd_n || !ext_wr_n) begin
            strb_run <= strb_run + (CNT_W+1)'(1);
        end else begin
            strb_run <= '0;
        end
    end

    a_r5_strobe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> (strb_run < (CNT_W+1)'(MAX_STRB)))
        else $error("strobe longer than the largest stretch allows");

    a_r6_latch_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> !$past(ext_ale))
        else $error("strobe began without a setup gap after ALE");

    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != XS_IDLE) && ($past(phase) != XS_IDLE)) |-> $stable(ext_addr))
        else $error("external address moved during an access");
endmodule

// File: rtl/xdata_router.sv
// External data space router: sends each access to the internal SRAM
// window or to the stretched external bus, and reports completion.
// Assumes the requester waits for done before the next request and the
// SRAM returns read data one clock after its enable.
module xdata_router #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ST_W      = 3,
    parameter int MC_CLKS   = 4,
    parameter int INT_BYTES = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic                          int_en,
    input  logic [ST_W-1:0]               stretch,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          done,
    output logic                          sram_en,
    output logic                          sram_we,
    output logic [$clog2(INT_BYTES)-1:0]  sram_addr,
    output logic [DATA_W-1:0]             sram_wdata,
    input  logic [DATA_W-1:0]             sram_rdata,
    output logic [ADDR_W-1:0]             ext_addr,
    output logic [DATA_W-1:0]             ext_dout,
    output logic                          ext_oe,
    input  logic [DATA_W-1:0]             ext_din,
    output logic                          ext_ale,
    output logic                          ext_rd_n,
    output logic                          ext_wr_n
);
    localparam int IA_W = $clog2(INT_BYTES);

    logic              to_int;
    logic              accept;
    logic              ext_idle;
    logic              ext_fin;
    logic [DATA_W-1:0] ext_rdata;
    logic [1:0]        int_ph;
    logic              int_done;
    logic [DATA_W-1:0] int_rdata_q;
    logic              from_int;

    xdata_decode #(
        .ADDR_W    (ADDR_W),
        .INT_BYTES (INT_BYTES)
    ) dec_i (
        .addr   (req_addr),
        .int_en (int_en),
        .to_int (to_int)
    );

    // A request is taken only when both paths are idle
    always_comb begin
        accept = req_valid && ext_idle && (int_ph == 2'd0);
    end

    xdata_ext_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ST_W    (ST_W),
        .MC_CLKS (MC_CLKS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && !to_int),
        .write    (req_write),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .stretch  (stretch),
        .ext_din  (ext_din),
        .idle     (ext_idle),
        .fin      (ext_fin),
        .rdata    (ext_rdata),
        .ext_addr (ext_addr),
        .ext_dout (ext_dout),
        .ext_oe   (ext_oe),
        .ext_ale  (ext_ale),
        .ext_rd_n (ext_rd_n),
        .ext_wr_n (ext_wr_n)
    );

    // Internal path: one enable clock, one SRAM latency clock, then capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_ph      <= 2'd0;
            sram_en     <= 1'b0;
            sram_we     <= 1'b0;
            sram_addr   <= '0;
            sram_wdata  <= '0;
            int_done    <= 1'b0;
            int_rdata_q <= '0;
        end else begin
            sram_en  <= 1'b0;
            sram_we  <= 1'b0;
            int_done <= 1'b0;
            unique case (int_ph)
                2'd0: begin
                    if (accept && to_int) begin
                        int_ph     <= 2'd1;
                        sram_en    <= 1'b1;
                        sram_we    <= req_write;
                        sram_addr  <= req_addr[IA_W-1:0];
                        sram_wdata <= req_wdata;
                    end
                end
                2'd1: int_ph <= 2'd2;
                2'd2: begin
                    int_ph      <= 2'd0;
                    int_done    <= 1'b1;
                    int_rdata_q <= sram_rdata;
                end
                default: int_ph <= 2'd0;
            endcase
        end
    end

    // Remember which path serves the access in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_int <= 1'b0;
        end else if (accept) begin
            from_int <= to_int;
        end
    end

    // Result and completion merge
    always_comb begin
        done    = int_done | ext_fin;
        rd_data = from_int ? int_rdata_q : ext_rdata;
    end

    a_r1_int_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> (ext_rd_n && ext_wr_n && !ext_ale))
        else $error("external bus active during an SRAM access");

    a_r2_no_sram_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> !sram_en)
        else $error("SRAM enabled during an external strobe");

    a_r4_int_latency: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> ##2 done)
        else $error("internal access did not finish on time");

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one clock");
endmodule

// File: tb/xdata_router_tb_top.sv
// Scoreboard bench: the driver queues expected items, the monitor measures
// each access at the pins and compares when done appears.
module xdata_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, int_en;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, ext_din, rd_data, sram_wdata, sram_rdata, ext_dout;
    logic [2:0]  stretch;
    logic        done, sram_en, sram_we, ext_oe, ext_ale, ext_rd_n, ext_wr_n;
    logic [9:0]  sram_addr;
    logic [15:0] ext_addr;

    always #4 clk = ~clk;

    xdata_router dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .int_en(int_en),
        .stretch(stretch), .rd_data(rd_data), .done(done), .sram_en(sram_en),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_oe(ext_oe), .ext_din(ext_din), .ext_ale(ext_ale),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    // SRAM model with one clock of read latency
    logic [7:0] mem [0:1023];
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata     <= mem[sram_addr];
        end
    end

    typedef struct {
        bit          is_int;
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  exp_rd;
        int          lat;
        int          strb;
        int          setup;
        string       rtag;
        string       stag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] shadow [0:1023];
    int total = 0;
    int bad   = 0;
    int done_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: queue the expectation, then issue one access
    task automatic do_acc(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input bit en, input int st, input int perturb);
        exp_t e;
        int   n0;
        int   guard;
        e.wr    = wr;
        e.addr  = a;
        e.wdata = d;
        e.is_int = en && (a < 16'h0400);
        e.stag  = (perturb != 0) ? "R10" : "R5";
        if (e.is_int) begin
            e.lat = 2; e.strb = 0; e.setup = 0;
            e.rtag = (perturb != 0) ? "R10" : "R1";
            e.exp_rd = wr ? 8'h00 : shadow[a[9:0]];
            if (wr) shadow[a[9:0]] = d;
        end else begin
            e.lat   = (st == 0) ? 8 : 4 * (st + 2);
            e.strb  = (st == 0) ? 2 : 4 * st;
            e.setup = (st == 0) ? 4 : 5;
            e.rtag  = (perturb != 0) ? "R10" : (en ? "R2" : "R3");
            e.exp_rd = d;
        end
        exp_q.push_back(e);
        n0 = done_cnt;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        int_en = en; stretch = 3'(st); ext_din = d;
        @(posedge clk); #2;
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        if (perturb == 1) stretch = 3'd7;
        if (perturb == 2) int_en = ~en;
        guard = 0;
        while (done_cnt == n0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(posedge clk);
    endtask

    // Monitor: measure each access at the pins and score it at done
    bit  run = 0;
    bit  prev_done = 0;
    int  t, strb, first, alec, semc;
    bit  wr_ok, sram_ok, addr_ok;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!done, "R9", "done width", done, 0);
            prev_done = done;
        end
        if (run && exp_q.size() > 0) begin
            exp_t cur;
            cur = exp_q[0];
            t++;
            if (!ext_rd_n || !ext_wr_n) begin
                strb++;
                if (first == 0) first = t;
            end
            if (!ext_wr_n && !(ext_oe && ext_dout == cur.wdata)) wr_ok = 0;
            if ((!ext_rd_n && cur.wr) || (!ext_wr_n && !cur.wr)) wr_ok = 0;
            if (ext_ale) alec++;
            if (sram_en) begin
                semc++;
                if (sram_addr != cur.addr[9:0] || sram_we != cur.wr ||
                    (cur.wr && sram_wdata != cur.wdata)) sram_ok = 0;
            end
            if (!cur.is_int && ext_addr != cur.addr) addr_ok = 0;
            if (done || t > 60) begin
                check(t == cur.lat + 1, cur.is_int ? "R4" : "R7", "latency", t, cur.lat + 1);
                check(strb == cur.strb, cur.is_int ? "R1" : cur.stag, "strobe clocks", strb, cur.strb);
                check(semc == (cur.is_int ? 1 : 0), cur.rtag, "sram enables", semc, cur.is_int ? 1 : 0);
                if (cur.is_int) begin
                    check(alec == 0, "R1", "ale clocks", alec, 0);
                    check(sram_ok, "R1", "sram fields", sram_addr, cur.addr[9:0]);
                end else begin
                    check(first == cur.setup + 1, "R6", "strobe start", first, cur.setup + 1);
                    check(alec == 2, "R6", "ale clocks", alec, 2);
                    check(wr_ok, "R8", "strobe kind and write data", ext_dout, cur.wdata);
                    check(addr_ok, "R9", "address held", ext_addr, cur.addr);
                end
                if (!cur.wr)
                    check(rd_data == cur.exp_rd, cur.is_int ? "R4" : "R8", "read data", rd_data, cur.exp_rd);
                void'(exp_q.pop_front());
                run = 0;
                done_cnt++;
            end
        end else if (rst_n && req_valid) begin
            run = 1; t = 0; strb = 0; first = 0; alec = 0; semc = 0;
            wr_ok = 1; sram_ok = 1; addr_ok = 1;
        end
    end

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; int_en = 1'b0; stretch = 3'd1; ext_din = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!done && !ext_ale && !ext_oe && !sram_en && ext_rd_n && ext_wr_n,
              "R11", "reset outputs", {done, ext_ale, ext_oe, sram_en, ext_rd_n, ext_wr_n}, 6'b000011);
        @(posedge clk); #2;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        do_acc(1'b0, 16'h0010, 8'h5A, 1'b0, 0, 0);   // R3 low address, window off
        do_acc(1'b1, 16'h0000, 8'hA5, 1'b1, 3, 0);   // R1 R4 bottom of window
        do_acc(1'b1, 16'h03FF, 8'h3C, 1'b1, 7, 0);   // R1 R4 top of window, max stretch
        do_acc(1'b0, 16'h0000, 8'h00, 1'b1, 7, 0);   // R4 read back
        do_acc(1'b0, 16'h03FF, 8'h00, 1'b1, 0, 0);   // R4 read back
        do_acc(1'b0, 16'h0400, 8'h77, 1'b1, 0, 0);   // R2 first address past window
        for (int n = 0; n < 8; n++) begin
            do_acc(1'b0, 16'h8000 + 16'(n), 8'h40 + 8'(n), 1'b1, n, 0);  // R5 R6 R7 reads
            do_acc(1'b1, 16'hFFFF, 8'hC0 + 8'(n), 1'b0, n, 0);          // R5 R8 writes
        end
        do_acc(1'b0, 16'h03FF, 8'h99, 1'b0, 2, 0);   // R3 top of window, window off
        do_acc(1'b0, 16'h1234, 8'h1E, 1'b1, 2, 1);   // R10 stretch changed mid-access
        do_acc(1'b0, 16'h0000, 8'h00, 1'b1, 1, 2);   // R10 enable dropped mid-access
        do_acc(1'b0, 16'h0200, 8'h6B, 1'b0, 1, 2);   // R10 enable raised mid-access

        repeat (5) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule